// File: doc/BRIEF.md
# Cascaded dual interrupt controller

This block combines two 8-input priority interrupt controllers into one 16-line interrupt unit. One controller is the master and one is the slave, and the slave's pending state drives master input 2. Each controller holds three registers: a pending-request register, a mask register and an in-service register. The block drives one interrupt line to the CPU. A small resolution state machine recomputes that line after every event that can change the outcome: a request, a mask write, an end-of-interrupt or an acknowledge.

Software talks to the block through a single command port. Each command carries a line number, an operation and a data byte. The operations are a level-mode request, a pulse-mode request, a mask write and an end-of-interrupt. The CPU side uses a one-cycle acknowledge strobe, and the block returns the vector of the request it grants.

The resolution sequence has four states:
- `ST_IDLE` accepts one event.
- `ST_SLAVE` refreshes master input 2 from the slave.
- `ST_MASTER` decides the CPU line.
- `ST_SCRUB` clears a cascade request that has no slave request to serve.

The transitions are:
- IDLE→SLAVE on any accepted event.
- SLAVE→MASTER always.
- MASTER→SCRUB on a stale cascade.
- SCRUB→MASTER always.
- MASTER→IDLE otherwise.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, the pending and in-service registers are clear, `cpu_irq` is 0 and `cmd_ready` is 1. A pulse request on a line that is still masked leaves `cpu_irq` at 0.
- R2: Bit 3 of a line number selects the controller (0 = master, 1 = slave), and bits 2:0 select the input. The granted vector is `{base, input}`: with the defaults, master inputs give 8..15 and slave inputs give 112..119.
- R3: Command op 0 is a level-mode request, and `cmd_data[0]` is the new line level. Only a 0→1 transition of the line sets its pending bit. Writing 1 to a line that is already high sets nothing.
- R4: Command op 1 is a pulse-mode request. It always sets the pending bit, even when the line is already high, and leaves the line high. A later level-mode write of 1 therefore gives no new request.
- R5: A controller's winner is the lowest-numbered input that is pending and unmasked and has no in-service bit at its own or a lower index. An input blocked by in-service does not raise `cpu_irq`.
- R6: Master pending bit 2 is refreshed from the slave: it is 1 exactly when the slave has any pending, unmasked input. A request command on line 2 has no effect.
- R7: Once `cmd_ready` returns to 1, `cpu_irq` is 1 exactly when the master has a winner that is not a stale cascade.
- R8: If the master's winner is input 2 while the slave has no winner, master bit 2 is cleared. Resolution then runs again, so that a lower-priority master input can win.
- R9: Command op 2 writes `cmd_data` into the mask of the controller selected by bit 3 of `cmd_line`. If that write masks the request that was winning before it, `cpu_irq` drops at the accepting edge. If that request came from the slave, master bit 2 is also cleared.
- R10: When `ack_req` is accepted, `ack_done` pulses one cycle later with `ack_vector`. The winner moves from pending to in-service on the master, and also on the slave when the master's winner is input 2. With no deliverable request, the vector is `{master base, 7}` and no state changes.
- R11: Command op 3 clears the lowest-indexed in-service bit of the controller selected by bit 3 of `cmd_line`.
- R12: Commands and acknowledges are accepted only in `ST_IDLE`. `cmd_ready` is 0 from the accepting edge until resolution ends. An acknowledge takes precedence over a command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 level request, 1 pulse request, 2 mask write, 3 end-of-interrupt |
| cmd_line | input | 4 | Line number; bit 3 selects the controller |
| cmd_data | input | 8 | Mask value, or line level in bit 0 |
| cmd_ready | output | 1 | Command or acknowledge can be accepted |
| ack_req | input | 1 | CPU acknowledge strobe |
| ack_done | output | 1 | Vector valid, one cycle |
| ack_vector | output | 8 | Granted vector number |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: 8 inputs per controller, the cascade on input 2, and bases 1 and 14. These defaults put master vectors (8..15) and slave vectors (112..119) in ranges that cannot be confused, so a cascaded grant and a direct grant are told apart from the vector alone. With the cascade on input 2, a slave request blocked by slave in-service while master input 6 is pending drives the scrub loop through `ST_SCRUB`. The sequence then shows input 6 being granted.

// File: rtl/cascade_irq_pkg.sv
package cascade_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SLAVE  = 2'd1,
        ST_MASTER = 2'd2,
        ST_SCRUB  = 2'd3
    } rs_state_e;

    typedef enum logic [1:0] {
        OP_LEVEL = 2'd0,
        OP_PULSE = 2'd1,
        OP_MASK  = 2'd2,
        OP_EOI   = 2'd3
    } cmd_op_e;

endpackage

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int N_IN = 8,
    localparam int IW = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] irr,
    input  logic [N_IN-1:0] imr,
    input  logic [N_IN-1:0] isr,
    output logic            win_valid,
    output logic [IW-1:0]   win_idx
);

    logic blocked;

    // Scan from input 0 upward; an in-service bit stops the scan at its index.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        blocked   = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (!blocked && !win_valid) begin
                if (isr[i]) begin
                    blocked = 1'b1;
                end else if (irr[i] && !imr[i]) begin
                    win_valid = 1'b1;
                    win_idx   = i[IW-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/irq_line_capture.sv
module irq_line_capture #(
    parameter int LINES = 16,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_line,
    input  logic             wr_pulse,
    input  logic             wr_level,
    output logic [LINES-1:0] set_vec
);

    logic [LINES-1:0] lvl_q;

    // A pulse is a low-then-high drive, so it always yields an edge.
    always_comb begin
        set_vec = '0;
        if (wr_en) begin
            if (wr_pulse) begin
                set_vec[wr_line] = 1'b1;
            end else if (wr_level && !lvl_q[wr_line]) begin
                set_vec[wr_line] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (wr_en) begin
            lvl_q[wr_line] <= wr_pulse ? 1'b1 : wr_level;
        end
    end

endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
    import cascade_irq_pkg::*;
#(
    parameter int          N_IN        = 8,
    parameter int          CASCADE_IN  = 2,
    parameter int          BASE_W      = 5,
    parameter logic [4:0]  MASTER_BASE = 5'd1,
    parameter logic [4:0]  SLAVE_BASE  = 5'd14,
    localparam int IW    = $clog2(N_IN),
    localparam int LW    = IW + 1,
    localparam int VEC_W = BASE_W + IW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [LW-1:0]    cmd_line,
    input  logic [N_IN-1:0]  cmd_data,
    output logic             cmd_ready,
    input  logic             ack_req,
    output logic             ack_done,
    output logic [VEC_W-1:0] ack_vector,
    output logic             cpu_irq
);

    localparam int          LINES   = 2 * N_IN;
    localparam logic [IW-1:0] CAS_IDX = IW'(CASCADE_IN);
    localparam logic [IW-1:0] SPUR_IDX = IW'(N_IN - 1);

    // Index 0 is the master controller, index 1 the slave.
    logic [1:0][N_IN-1:0] irr_q;
    logic [1:0][N_IN-1:0] imr_q;
    logic [1:0][N_IN-1:0] isr_q;
    logic [1:0]           win_valid;
    logic [1:0][IW-1:0]   win_idx;

    rs_state_e state_q, state_d;

    logic             cmd_fire;
    logic             ack_fire;
    logic             is_req_op;
    logic [LINES-1:0] set_vec;
    logic [N_IN-1:0]  cas_bit;
    logic             tgt_slave;
    logic             m_deliv;
    logic             win_from_slave;
    logic             stale_cas;
    logic             mask_drop;
    logic             slave_any;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_ctrl
            irq_prio_resolver #(.N_IN(N_IN)) u_res (
                .irr       (irr_q[g]),
                .imr       (imr_q[g]),
                .isr       (isr_q[g]),
                .win_valid (win_valid[g]),
                .win_idx   (win_idx[g])
            );
        end
    endgenerate

    assign cmd_ready = (state_q == ST_IDLE) && !ack_req;
    assign ack_fire  = (state_q == ST_IDLE) && ack_req;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign is_req_op = (cmd_op == OP_LEVEL) || (cmd_op == OP_PULSE);
    assign tgt_slave = cmd_line[LW-1];

    irq_line_capture #(.LINES(LINES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmd_fire && is_req_op),
        .wr_line  (cmd_line),
        .wr_pulse (cmd_op == OP_PULSE),
        .wr_level (cmd_data[0]),
        .set_vec  (set_vec)
    );

    always_comb begin
        cas_bit          = '0;
        cas_bit[CAS_IDX] = 1'b1;
    end

    assign win_from_slave = win_valid[0] && (win_idx[0] == CAS_IDX);
    assign m_deliv        = win_valid[0] && (!win_from_slave || win_valid[1]);
    assign stale_cas      = win_from_slave && !win_valid[1];
    assign slave_any      = |(irr_q[1] & ~imr_q[1]);

    // Winner captured before the mask write lands; does the new mask hide it?
    always_comb begin
        mask_drop = 1'b0;
        if (cmd_fire && (cmd_op == OP_MASK) && m_deliv) begin
            if (win_from_slave) begin
                mask_drop = tgt_slave && cmd_data[win_idx[1]];
            end else begin
                mask_drop = !tgt_slave && cmd_data[win_idx[0]];
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ack_fire || cmd_fire) state_d = ST_SLAVE;
            ST_SLAVE:  state_d = ST_MASTER;
            ST_MASTER: state_d = stale_cas ? ST_SCRUB : ST_IDLE;
            ST_SCRUB:  state_d = ST_MASTER;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Controller registers and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q      <= '0;
            imr_q      <= '1;
            isr_q      <= '0;
            cpu_irq    <= 1'b0;
            ack_done   <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (ack_fire) begin
                        ack_done <= 1'b1;
                        if (m_deliv && win_from_slave) begin
                            isr_q[1][win_idx[1]] <= 1'b1;
                            irr_q[1][win_idx[1]] <= 1'b0;
                            isr_q[0][CAS_IDX]    <= 1'b1;
                            irr_q[0][CAS_IDX]    <= 1'b0;
                            ack_vector           <= {SLAVE_BASE, win_idx[1]};
                        end else if (m_deliv) begin
                            isr_q[0][win_idx[0]] <= 1'b1;
                            irr_q[0][win_idx[0]] <= 1'b0;
                            ack_vector           <= {MASTER_BASE, win_idx[0]};
                        end else begin
                            ack_vector <= {MASTER_BASE, SPUR_IDX};
                        end
                    end else if (cmd_fire) begin
                        unique case (cmd_op)
                            OP_LEVEL, OP_PULSE: begin
                                irr_q[0] <= irr_q[0] | (set_vec[N_IN-1:0] & ~cas_bit);
                                irr_q[1] <= irr_q[1] | set_vec[LINES-1:N_IN];
                            end
                            OP_MASK: begin
                                imr_q[tgt_slave] <= cmd_data;
                                if (mask_drop) begin
                                    cpu_irq <= 1'b0;
                                    if (win_from_slave) irr_q[0][CAS_IDX] <= 1'b0;
                                end
                            end
                            OP_EOI: begin
                                isr_q[tgt_slave] <= isr_q[tgt_slave] & (isr_q[tgt_slave] - 1'b1);
                            end
                            default: ;
                        endcase
                    end
                end
                ST_SLAVE: begin
                    irr_q[0][CAS_IDX] <= slave_any;
                end
                ST_MASTER: begin
                    cpu_irq <= win_valid[0] && !stale_cas;
                end
                ST_SCRUB: begin
                    irr_q[0][CAS_IDX] <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cascade_irq_ctrl_chk.sv
module cascade_irq_ctrl_chk
    import cascade_irq_pkg::*;
#(
    parameter int         N_IN        = 8,
    parameter int         CASCADE_IN  = 2,
    parameter logic [4:0] MASTER_BASE = 5'd1,
    parameter logic [4:0] SLAVE_BASE  = 5'd14,
    parameter int         VEC_W       = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input rs_state_e            state_q,
    input logic [1:0][N_IN-1:0] irr_q,
    input logic [1:0][N_IN-1:0] imr_q,
    input logic [1:0]           win_valid,
    input logic                 win_from_slave,
    input logic                 ack_req,
    input logic                 ack_done,
    input logic [VEC_W-1:0]     ack_vector,
    input logic                 cpu_irq
);

    // R7: at rest the CPU line agrees with the master's deliverable winner
    a_r7_idle_irq_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cpu_irq == (win_valid[0] && !(win_from_slave && !win_valid[1]))));

    // R6: master cascade bit reflects slave pending state after the refresh step
    a_r6_cascade_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MASTER && $past(state_q) == ST_SLAVE)
        |-> (irr_q[0][CASCADE_IN] == $past(|(irr_q[1] & ~imr_q[1]))));

    // R8: the scrub step runs with the CPU line low and clears the cascade bit
    a_r8_scrub_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCRUB) |-> !cpu_irq);

    a_r8_scrub_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCRUB) |=> !irr_q[0][CASCADE_IN]);

    // R10: a vector only follows an acknowledge taken in idle
    a_r10_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done |-> ($past(ack_req) && $past(state_q) == ST_IDLE));

    // R2: every vector lies in one of the two base ranges
    a_r2_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done |-> (ack_vector[VEC_W-1:VEC_W-5] == MASTER_BASE ||
                      ack_vector[VEC_W-1:VEC_W-5] == SLAVE_BASE));

endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk #(
    .N_IN        (N_IN),
    .CASCADE_IN  (CASCADE_IN),
    .MASTER_BASE (MASTER_BASE),
    .SLAVE_BASE  (SLAVE_BASE),
    .VEC_W       (VEC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_q        (state_q),
    .irr_q          (irr_q),
    .imr_q          (imr_q),
    .win_valid      (win_valid),
    .win_from_slave (win_from_slave),
    .ack_req        (ack_req),
    .ack_done       (ack_done),
    .ack_vector     (ack_vector),
    .cpu_irq        (cpu_irq)
);

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb;

    localparam logic [1:0] C_LEVEL = 2'd0;
    localparam logic [1:0] C_PULSE = 2'd1;
    localparam logic [1:0] C_MASK  = 2'd2;
    localparam logic [1:0] C_EOI   = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [3:0] cmd_line = '0;
    logic [7:0] cmd_data = '0;
    logic       cmd_ready;
    logic       ack_req = 1'b0;
    logic       ack_done;
    logic [7:0] ack_vector;
    logic       cpu_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int    exp_vec_q[$];
    string exp_tag_q[$];

    always #4 clk = ~clk;

    cascade_irq_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_line   (cmd_line),
        .cmd_data   (cmd_data),
        .cmd_ready  (cmd_ready),
        .ack_req    (ack_req),
        .ack_done   (ack_done),
        .ack_vector (ack_vector),
        .cpu_irq    (cpu_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected vectors as grants appear
    always @(negedge clk) begin
        if (rst_n && ack_done) begin
            checks++;
            if (exp_vec_q.size() == 0) begin
                failures++;
                $display("FAIL R10 unexpected grant actual=%0d expected=none", ack_vector);
            end else begin
                int    ev;
                string et;
                ev = exp_vec_q.pop_front();
                et = exp_tag_q.pop_front();
                if (int'(ack_vector) != ev) begin
                    failures++;
                    $display("FAIL %s vector actual=%0d expected=%0d", et, ack_vector, ev);
                end
            end
        end
    end

    task automatic wait_idle();
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] op, input logic [3:0] line, input logic [7:0] data);
        wait_idle();
        cmd_op    = op;
        cmd_line  = line;
        cmd_data  = data;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [3:0] line, input logic [7:0] data);
        send(op, line, data);
        wait_idle();
    endtask

    task automatic do_ack(input int exp, input string tag);
        wait_idle();
        exp_vec_q.push_back(exp);
        exp_tag_q.push_back(tag);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset irq", cpu_irq, 0);
        check("R1 reset ready", cmd_ready, 1);
        check("R1 reset ack_done", ack_done, 0);

        do_cmd(C_PULSE, 4'd3, 8'h00);
        check("R1 masked line gives no irq", cpu_irq, 0);
        do_cmd(C_MASK, 4'd0, 8'h00);
        check("R7 unmask raises irq", cpu_irq, 1);
        do_ack(11, "R2 master vector");
        check("R7 irq low after grant", cpu_irq, 0);

        do_cmd(C_PULSE, 4'd5, 8'h00);
        check("R5 in-service blocks lower", cpu_irq, 0);
        do_cmd(C_EOI, 4'd0, 8'h00);
        check("R11 eoi releases lower", cpu_irq, 1);
        do_ack(13, "R10 line5 grant");
        do_cmd(C_EOI, 4'd0, 8'h00);

        do_cmd(C_LEVEL, 4'd4, 8'h01);
        check("R3 rising level sets", cpu_irq, 1);
        do_ack(12, "R3 line4 grant");
        do_cmd(C_EOI, 4'd0, 8'h00);
        do_cmd(C_LEVEL, 4'd4, 8'h01);
        check("R3 held high no request", cpu_irq, 0);
        do_cmd(C_LEVEL, 4'd4, 8'h00);
        check("R3 falling no request", cpu_irq, 0);
        do_cmd(C_LEVEL, 4'd4, 8'h01);
        check("R3 new rising sets", cpu_irq, 1);
        do_ack(12, "R3 line4 regrant");
        do_cmd(C_EOI, 4'd0, 8'h00);

        do_cmd(C_PULSE, 4'd4, 8'h00);
        check("R4 pulse on high line sets", cpu_irq, 1);
        do_ack(12, "R4 pulse grant");
        do_cmd(C_EOI, 4'd0, 8'h00);
        do_cmd(C_LEVEL, 4'd4, 8'h01);
        check("R4 line stays high after pulse", cpu_irq, 0);

        do_cmd(C_PULSE, 4'd2, 8'h00);
        check("R6 line 2 ignored", cpu_irq, 0);
        do_ack(15, "R10 spurious vector");
        check("R10 spurious leaves irq low", cpu_irq, 0);

        do_cmd(C_PULSE, 4'd6, 8'h00);
        do_cmd(C_PULSE, 4'd1, 8'h00);
        do_ack(9, "R5 lowest input first");
        do_cmd(C_EOI, 4'd0, 8'h00);
        do_ack(14, "R5 next input");
        do_cmd(C_EOI, 4'd0, 8'h00);

        do_cmd(C_MASK, 4'd8, 8'h00);
        do_cmd(C_PULSE, 4'd9, 8'h00);
        check("R6 slave raises cascade", cpu_irq, 1);
        do_ack(113, "R6 slave vector");

        do_cmd(C_EOI, 4'd0, 8'h00);
        check("R6 no slave pending", cpu_irq, 0);
        do_cmd(C_PULSE, 4'd10, 8'h00);
        check("R8 stale cascade scrubbed", cpu_irq, 0);
        do_cmd(C_PULSE, 4'd6, 8'h00);
        check("R8 lower line wins", cpu_irq, 1);
        do_ack(14, "R8 scrub lets line6 win");
        check("R8 irq low after rescrub", cpu_irq, 0);
        do_cmd(C_EOI, 4'd0, 8'h00);
        do_cmd(C_EOI, 4'd8, 8'h00);
        check("R11 slave eoi releases", cpu_irq, 1);
        do_ack(114, "R11 slave grant");
        do_cmd(C_EOI, 4'd8, 8'h00);
        do_cmd(C_EOI, 4'd0, 8'h00);

        do_cmd(C_PULSE, 4'd12, 8'h00);
        check("R6 slave line12 raises", cpu_irq, 1);
        send(C_MASK, 4'd8, 8'h10);
        check("R9 slave mask drops at once", cpu_irq, 0);
        check("R12 busy after accept", cmd_ready, 0);
        wait_idle();
        check("R9 stays low", cpu_irq, 0);
        do_cmd(C_MASK, 4'd8, 8'h00);
        check("R9 unmask restores", cpu_irq, 1);
        do_ack(116, "R9 slave line12 grant");
        do_cmd(C_EOI, 4'd8, 8'h00);
        do_cmd(C_EOI, 4'd0, 8'h00);

        do_cmd(C_PULSE, 4'd7, 8'h00);
        check("R5 line7 raises", cpu_irq, 1);
        send(C_MASK, 4'd0, 8'h80);
        check("R9 master mask drops at once", cpu_irq, 0);
        wait_idle();
        check("R9 master stays low", cpu_irq, 0);
        do_cmd(C_MASK, 4'd0, 8'h00);
        do_ack(15, "R9 line7 grant");
        do_cmd(C_EOI, 4'd0, 8'h00);
        check("R7 all quiet", cpu_irq, 0);

        repeat (4) @(negedge clk);
        check("R10 all grants seen", exp_vec_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R12 watchdog actual=busy expected=idle");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule